// File: doc/BRIEF.md
# Message-unit interrupt status register

This block holds the interrupt status word of a host-to-local messaging unit. Three sticky bits record events reported by the queue managers: an overflow of the outbound free list, an overflow of the inbound post list, and a frame address posted into the inbound post queue by an external bus master. A fourth bit mirrors the machine-check request bit of the inbound doorbell register. A companion mask register, supplied as inputs, gates each bit.

The local processor reads the word over a simple register port at offset 0x100. It clears the queue bits by writing ones to them. The doorbell bit cannot be cleared by software. It clears only when its source level drops. Two registered outputs go to the processor core. The interrupt line carries the post-queue bit. The machine-check line carries the two overflow bits and the doorbell bit.

Top module: `msg_irq_status`

## Requirements
- R1: After reset every status bit reads 0, and `irq_o` and `mchk_o` are 0.
- R2: The implemented bits sit at positions 8 (outbound overflow), 7 (inbound overflow), 5 (post-queue) and 4 (doorbell machine check). All other bits of `bus_rdata` read as 0, and writing ones to them changes nothing.
- R3: Reads and writes take effect only when `bus_addr` equals 0x100 with `bus_sel` high. Any other access returns 0 on `bus_rdata` and leaves the status unchanged.
- R4: A one-cycle pulse on `evt_ofl_out_i` with `msk_ofl_out_i` low sets bit 8 on the next clock edge.
- R5: A pulse on `evt_ofl_in_i` with `msk_ofl_in_i` low sets bit 7.
- R6: A pulse on `evt_post_i` with `msk_post_i` low sets bit 5.
- R7: A write at 0x100 clears each of bits 8, 7 and 5 whose data bit is 1. Data bits of 0 leave those bits as they are.
- R8: An event whose mask input is 1 does not set its status bit, and the bit keeps its value.
- R9: When a set event and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R10: Bit 4 sets when `db_mchk_i` is high and `msk_db_i` is low. It stays set while `db_mchk_i` stays high, even if the mask rises later. It clears on the edge after `db_mchk_i` goes low. Writes to bit 4 have no effect.
- R11: One clock after the status word, `irq_o` equals bit 5 AND NOT `msk_post_i`. `mchk_o` equals the OR of bits 8, 7 and 4, each ANDed with its inverted mask input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the message-unit space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| evt_ofl_out_i | input | 1 | Outbound free-list overflow pulse |
| evt_ofl_in_i | input | 1 | Inbound post-list overflow pulse |
| evt_post_i | input | 1 | Frame address posted pulse |
| db_mchk_i | input | 1 | Doorbell machine-check level |
| msk_ofl_out_i | input | 1 | Mask for bit 8 |
| msk_ofl_in_i | input | 1 | Mask for bit 7 |
| msk_post_i | input | 1 | Mask for bit 5 |
| msk_db_i | input | 1 | Mask for bit 4 |
| irq_o | output | 1 | Normal interrupt to the processor |
| mchk_o | output | 1 | Machine-check request to the processor |

## Verification
The hardest case to reach from the ports is a write-1-to-clear that lands in the same cycle as a fresh event on the same bit. The second hardest is a doorbell mask that changes while the doorbell level is held high. Directed sequences produce both cases on purpose. A long random run then adds sparse event pulses, frequent mask toggles, and writes at the right and wrong offsets with random data. A bench model tracks every bit and both outputs cycle by cycle.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;
   // status vector index order used inside the block
   localparam int IDX_OFL_OUT = 0;
   localparam int IDX_OFL_IN  = 1;
   localparam int IDX_POST    = 2;
   localparam int IDX_DB      = 3;
   localparam int NUM_STAT    = 4;
   localparam int NUM_EVT     = 3;

   // bit positions in the software-visible word
   localparam int POS_OFL_OUT = 8;
   localparam int POS_OFL_IN  = 7;
   localparam int POS_POST    = 5;
   localparam int POS_DB      = 4;

   typedef enum logic {ROUTE_IRQ = 1'b0, ROUTE_MCHK = 1'b1} route_e;

   function automatic int stat_pos(input int idx);
      case (idx)
         IDX_OFL_OUT: return POS_OFL_OUT;
         IDX_OFL_IN:  return POS_OFL_IN;
         IDX_POST:    return POS_POST;
         default:     return POS_DB;
      endcase
   endfunction

   function automatic route_e stat_route(input int idx);
      return (idx == IDX_POST) ? ROUTE_IRQ : ROUTE_MCHK;
   endfunction
endpackage

// File: rtl/irq_evt_bit.sv
module irq_evt_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic mask_i,
   input  logic clr_i,
   output logic stat_o
);
   logic set_ok;
   assign set_ok = evt_i & ~mask_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat_o <= 1'b0;
      else if (set_ok) stat_o <= 1'b1;
      else if (clr_i)  stat_o <= 1'b0;
   end

   // R9 set beats clear, R4..R6 unmasked event sets
   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i && !mask_i) |=> stat_o);
   // R7 write-1 clears when no event arrives
   assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !(evt_i && !mask_i)) |=> !stat_o);
   // R8 masked event with no clear leaves the bit alone
   assert_masked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_i && !clr_i) |=> $stable(stat_o));
endmodule

// File: rtl/irq_follow_bit.sv
module irq_follow_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic mask_i,
   output logic stat_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_o <= 1'b0;
      else        stat_o <= lvl_i & (stat_o | ~mask_i);
   end

   assert_db_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl_i |=> !stat_o);
   assert_db_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_i && stat_o) |=> stat_o);
   assert_db_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_o && mask_i) |=> !stat_o);
endmodule

// File: rtl/irq_route.sv
module irq_route #(
   parameter int               N        = 4,
   parameter logic [N-1:0]     MCHK_SEL = '1,
   parameter bit               OUT_REG  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] stat_i,
   input  logic [N-1:0] mask_i,
   output logic         irq_o,
   output logic         mchk_o
);
   logic [N-1:0] live;
   logic         irq_d, mchk_d;

   assign live   = stat_i & ~mask_i;
   assign irq_d  = |(live & ~MCHK_SEL);
   assign mchk_d = |(live &  MCHK_SEL);

   if (N < 1) begin : g_bad_n
      $error("irq_route: N must be at least 1");
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_o  <= 1'b0;
            mchk_o <= 1'b0;
         end else begin
            irq_o  <= irq_d;
            mchk_o <= mchk_d;
         end
      end

      assert_mchk_route_R11: assert property (@(posedge clk) disable iff (!rst_n)
         ((stat_i & ~mask_i & MCHK_SEL) != '0) |=> mchk_o);
      assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
         ((stat_i & ~mask_i & ~MCHK_SEL) == '0) |=> !irq_o);
   end else begin : g_comb
      assign irq_o  = irq_d;
      assign mchk_o = mchk_d;
   end
endmodule

// File: rtl/msg_irq_status.sv
module msg_irq_status
   import msg_irq_pkg::*;
#(
   parameter int          ADDR_W     = 12,
   parameter int          DATA_W     = 32,
   parameter logic [11:0] REG_OFFSET = 12'h100,
   parameter bit          OUT_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              evt_ofl_out_i,
   input  logic              evt_ofl_in_i,
   input  logic              evt_post_i,
   input  logic              db_mchk_i,
   input  logic              msk_ofl_out_i,
   input  logic              msk_ofl_in_i,
   input  logic              msk_post_i,
   input  logic              msk_db_i,
   output logic              irq_o,
   output logic              mchk_o
);
   localparam int MIN_DATA_W = POS_OFL_OUT + 1;
   localparam logic [NUM_STAT-1:0] MCHK_SEL = compute_sel();

   function automatic logic [NUM_STAT-1:0] compute_sel();
      logic [NUM_STAT-1:0] s;
      for (int i = 0; i < NUM_STAT; i++) s[i] = (stat_route(i) == ROUTE_MCHK);
      return s;
   endfunction

   if (DATA_W < MIN_DATA_W) begin : g_bad_dw
      $error("msg_irq_status: DATA_W too small for bit map");
   end
   if (ADDR_W < 9 || ADDR_W > 12) begin : g_bad_aw
      $error("msg_irq_status: ADDR_W must lie in 9..12");
   end

   logic                 hit, hit_wr, hit_rd;
   logic [NUM_STAT-1:0]  stat;
   logic [NUM_STAT-1:0]  mask;
   logic [NUM_EVT-1:0]   evt;
   logic [DATA_W-1:0]    rd_word;

   assign hit    = bus_sel && (bus_addr == REG_OFFSET[ADDR_W-1:0]);
   assign hit_wr = hit && bus_wr;
   assign hit_rd = hit && !bus_wr;

   assign evt  = {evt_post_i, evt_ofl_in_i, evt_ofl_out_i};
   assign mask = {msk_db_i, msk_post_i, msk_ofl_in_i, msk_ofl_out_i};

   for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
      localparam int P = stat_pos(g);
      irq_evt_bit u_bit (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt_i  (evt[g]),
         .mask_i (mask[g]),
         .clr_i  (hit_wr && bus_wdata[P]),
         .stat_o (stat[g])
      );
   end

   irq_follow_bit u_db (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (db_mchk_i),
      .mask_i (mask[IDX_DB]),
      .stat_o (stat[IDX_DB])
   );

   irq_route #(.N(NUM_STAT), .MCHK_SEL(MCHK_SEL), .OUT_REG(OUT_REG)) u_route (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_i (stat),
      .mask_i (mask),
      .irq_o  (irq_o),
      .mchk_o (mchk_o)
   );

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NUM_STAT; i++) rd_word[stat_pos(i)] = stat[i];
   end

   assign bus_rdata = hit_rd ? rd_word : '0;

   logic unused_wdata;
   assign unused_wdata = ^{bus_wdata[DATA_W-1:POS_OFL_OUT+1], bus_wdata[6], bus_wdata[4:0]};

   assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[DATA_W-1:9] == '0) && !bus_rdata[6] && (bus_rdata[3:0] == 4'h0));
   assert_miss_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_addr != REG_OFFSET[ADDR_W-1:0]) |-> (bus_rdata == '0));
endmodule

// File: tb/msg_irq_status_tb_top.sv
`timescale 1ns/1ps
module msg_irq_status_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 0, bus_wr = 0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        e_oo = 0, e_oi = 0, e_po = 0, db = 0;
   logic        m_oo = 0, m_oi = 0, m_po = 0, m_db = 0;
   logic        irq_o, mchk_o;

   int n_tests = 0, n_fail = 0;
   logic [3:0] ms = '0;   // model: {db, post, ofl_in, ofl_out}
   logic       mi = 0, mm = 0;
   bit         done = 0;

   always #2.5 clk = ~clk;

   msg_irq_status dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_ofl_out_i(e_oo), .evt_ofl_in_i(e_oi), .evt_post_i(e_po),
      .db_mchk_i(db), .msk_ofl_out_i(m_oo), .msk_ofl_in_i(m_oi),
      .msk_post_i(m_po), .msk_db_i(m_db), .irq_o(irq_o), .mchk_o(mchk_o)
   );

   function automatic logic [31:0] pack(input logic [3:0] s);
      logic [31:0] w = '0;
      w[8] = s[0]; w[7] = s[1]; w[5] = s[2]; w[4] = s[3];
      return w;
   endfunction

   function automatic logic [3:0] next_stat(input logic [3:0] s, input logic [2:0] ev,
         input logic [3:0] mk, input logic lv, input logic wr_hit, input logic [31:0] wd);
      logic [3:0] n;
      logic [2:0] clr = {wd[5], wd[7], wd[8]} & {3{wr_hit}};
      for (int i = 0; i < 3; i++) n[i] = (ev[i] & ~mk[i]) | (s[i] & ~clr[i]);
      n[3] = lv & (s[3] | ~mk[3]);
      return n;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one cycle: drive, check read data, clock, update model, check outputs
   task automatic step(input string req, input logic [2:0] ev, input logic lv,
         input logic [3:0] mk, input logic sel, input logic wr,
         input logic [11:0] ad, input logic [31:0] wd);
      logic hit;
      @(negedge clk);
      {e_po, e_oi, e_oo} = ev; db = lv;
      {m_db, m_po, m_oi, m_oo} = mk;
      bus_sel = sel; bus_wr = wr; bus_addr = ad; bus_wdata = wd;
      hit = sel && (ad == 12'h100);
      #1;
      if (sel && !wr) chk(req, bus_rdata, hit ? pack(ms) : 32'h0);
      @(posedge clk);
      mi = ms[2] & ~mk[2];
      mm = |(ms & ~mk & 4'b1011);
      ms = next_stat(ms, ev, mk, lv, hit && wr, wd);
      #1;
      chk("R11 irq_o", {31'h0, irq_o}, {31'h0, mi});
      chk("R11 mchk_o", {31'h0, mchk_o}, {31'h0, mm});
   endtask

   task automatic rd(input string req);
      step(req, 3'b000, db, {m_db, m_po, m_oi, m_oo}, 1, 0, 12'h100, 0);
   endtask

   initial begin
      #750000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      chk("R1 outputs", {30'h0, irq_o, mchk_o}, 32'h0);
      @(negedge clk); rst_n = 1;
      rd("R1 reset word");

      // R4 R5 R6 single events
      step("R4", 3'b001, 0, 4'h0, 0, 0, 0, 0); rd("R4 bit8");
      step("R5", 3'b010, 0, 4'h0, 0, 0, 0, 0); rd("R5 bit7");
      step("R6", 3'b100, 0, 4'h0, 0, 0, 0, 0); rd("R6 bit5");
      // R7 write zeros, then clear one bit at a time
      step("R7", 0, 0, 4'h0, 1, 1, 12'h100, 32'h0); rd("R7 zeros no effect");
      step("R7", 0, 0, 4'h0, 1, 1, 12'h100, 32'h100); rd("R7 clear bit8");
      step("R7", 0, 0, 4'h0, 1, 1, 12'h100, 32'h0A0); rd("R7 clear bits7,5");
      // R8 masked events do not set
      step("R8", 3'b111, 0, 4'h7, 0, 0, 0, 0); rd("R8 masked");
      // R9 set and clear same cycle
      step("R6", 3'b100, 0, 4'h0, 0, 0, 0, 0);
      step("R9", 3'b100, 0, 4'h0, 1, 1, 12'h100, 32'h1A0); rd("R9 set wins");
      // R2 reserved bits and R3 wrong offset
      step("R2", 0, 0, 4'h0, 1, 1, 12'h100, 32'hFFFF_FE4F); rd("R2 reserved");
      step("R4", 3'b011, 0, 4'h0, 0, 0, 0, 0);
      step("R3", 0, 0, 4'h0, 1, 1, 12'h104, 32'hFFFF_FFFF);
      step("R3 miss read", 0, 0, 4'h0, 1, 0, 12'h000, 0); rd("R3 unchanged");
      // R10 doorbell follower
      step("R10", 0, 1, 4'h0, 0, 0, 0, 0); rd("R10 set");
      step("R10", 0, 1, 4'h8, 1, 1, 12'h100, 32'h10); rd("R10 hold under mask and write");
      step("R10", 0, 0, 4'h0, 0, 0, 0, 0); rd("R10 drop");
      step("R10", 0, 1, 4'h8, 0, 0, 0, 0); rd("R10 masked rise");

      // random phase
      for (int k = 0; k < 4000; k++) begin
         logic [2:0] ev;
         logic [11:0] ad;
         int r = $urandom_range(0, 9);
         ev = {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0)};
         ad = (r < 7) ? 12'h100 : ((r == 7) ? 12'h104 : 12'h000);
         step("R7 R8 R10 random", ev, ($urandom_range(0, 3) != 0) ? db : ~db,
              4'($urandom_range(0, 15)), ($urandom_range(0, 1) == 1),
              ($urandom_range(0, 2) == 0), ad, $urandom);
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule